// File: doc/BRIEF.md
# Borrowing Input Port for a Mesh Router

This block is one input port of a five-port router on a two-dimensional mesh. It takes whole 64-bit packets from the router upstream of it, one packet per transfer, because the network switches store-and-forward. Packets wait in a small FIFO whose depth is a parameter (2, 4 or 8). The port works out the output direction of the packet at the head of the FIFO with dimension-ordered routing: it corrects X first, then Y, and delivers locally when both coordinates match. It then raises a request toward that output port and pops the packet when that output grants it.

When its own FIFO is full, the port does not simply stall its upstream. A borrowing controller looks at the other three input ports of the same router in a fixed priority order. It picks the first one whose FIFO has room and whose side may legally hold the packet's direction under the turn rules of XY routing. It raises a request to that peer and, once the peer grants, hands the upstream packet over in that same cycle. The port also works the other way round: a write multiplexer in front of its FIFO accepts packets that peers offer to it. Its own upstream traffic always has priority, and when several peers offer at once the lowest peer slot wins.

Top module: `fx_inport`

## Requirements
- R1: A synchronous active-low reset empties the FIFO and clears any outstanding peer request. After reset `out_req`, `bor_req`, `lend_gnt` and `up_full` are all 0.
- R2: When `up_req` is high and the FIFO is not full, `up_gnt` is high in the same cycle and the packet is stored. Packets leave in the order they were stored, and `head_pkt` shows the oldest one.
- R3: `up_full` is high exactly when DEPTH packets are stored. No write happens while it is high.
- R4: `out_req` is one-hot for a non-empty FIFO, with bit 0 Local, 1 East, 2 West, 3 North, 4 South. The destination X sits in `head_pkt[COORD_W-1:0]` and Y in `head_pkt[2*COORD_W-1:COORD_W]`. X is corrected first (larger X is East), then Y (larger Y is North). Local is chosen when both match.
- R5: The head packet is popped only in a cycle where `out_gnt` is high on the bit that `out_req` asserts. A grant on any other bit has no effect.
- R6: When `up_req` is high and the FIFO is full, the controller probes the peer slots in order 0, 1, 2 and requests the first eligible one on `bor_req` from the next cycle. For an East port (PORT_SIDE 0) the slots are West, North, South. For a West port they are East, North, South; for North they are South, East, West; for South they are North, East, West.
- R7: A peer is eligible only if its `peer_full` bit is low and its side may hold the packet's direction. A North buffer holds Local or South. A South buffer holds Local or North. An East buffer holds Local, North, South or West. A West buffer holds Local, North, South or East.
- R8: In a cycle where `bor_gnt` matches the raised `bor_req` bit, `up_gnt` is high, `bor_pkt` equals `up_pkt`, and `bor_req` is 0 in the next cycle.
- R9: If no peer is eligible, `up_full` stays high, `up_gnt` stays low and `bor_req` stays 0.
- R10: A peer offer on `lend_req` is granted only when the FIFO is not full and no upstream packet is being written in that cycle. The lowest offering slot wins, and the granted packet is stored.
- R11: If the requested peer raises its `peer_full` bit before granting, the request is withdrawn in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Upstream offers a packet |
| up_pkt | input | PKT_W | Upstream packet |
| up_gnt | output | 1 | Packet taken this cycle (stored here or handed to a peer) |
| up_full | output | 1 | Own FIFO full; also seen by peers |
| out_req | output | 5 | One-hot request toward an output port |
| out_gnt | input | 5 | Output port grants |
| head_pkt | output | PKT_W | Oldest stored packet |
| bor_req | output | 3 | Request to place a packet in peer slot k |
| bor_gnt | input | 3 | Peer accepted the packet |
| peer_full | input | 3 | Full flags of the peer FIFOs |
| bor_pkt | output | PKT_W | Packet handed to the peer |
| lend_req | input | 3 | Peer slot k offers a packet to this FIFO |
| lend_pkt | input | 3*PKT_W | Offered packets, slot k at bits k*PKT_W upward |
| lend_gnt | output | 3 | Offer accepted |

## Verification
The hardest situation to reach is a borrow: the own FIFO has to stay full while the upstream still offers a packet and the peer flags take a chosen pattern. The bench fills the FIFO by writing DEPTH packets and withholding every output grant. It then offers random destinations against random `peer_full` masks, so each probe slot, the turn-rule refusals and the case with no eligible peer all occur. Some requests are granted, and in others the target peer fills up first, which exercises the withdrawal path.

// File: rtl/fx_pkg.sv
package fx_pkg;

    // Side of the router an input port sits on.
    typedef enum logic [1:0] {
        SIDE_E = 2'd0,
        SIDE_W = 2'd1,
        SIDE_N = 2'd2,
        SIDE_S = 2'd3
    } side_e;

    localparam int NDIR = 5;
    // One-hot direction bits.
    localparam logic [NDIR-1:0] DIR_L = 5'b00001;
    localparam logic [NDIR-1:0] DIR_E = 5'b00010;
    localparam logic [NDIR-1:0] DIR_W = 5'b00100;
    localparam logic [NDIR-1:0] DIR_N = 5'b01000;
    localparam logic [NDIR-1:0] DIR_S = 5'b10000;

    // Directions a buffer on a given side may hold under the XY turn rules.
    function automatic logic [NDIR-1:0] side_allowed(side_e s);
        case (s)
            SIDE_N:  return DIR_L | DIR_S;
            SIDE_S:  return DIR_L | DIR_N;
            SIDE_E:  return DIR_L | DIR_N | DIR_S | DIR_W;
            default: return DIR_L | DIR_N | DIR_S | DIR_E;
        endcase
    endfunction

    // Side of the peer in probe slot k for a port on side own.
    function automatic side_e peer_side(side_e own, int k);
        case (own)
            SIDE_E:  return (k == 0) ? SIDE_W : (k == 1) ? SIDE_N : SIDE_S;
            SIDE_W:  return (k == 0) ? SIDE_E : (k == 1) ? SIDE_N : SIDE_S;
            SIDE_N:  return (k == 0) ? SIDE_S : (k == 1) ? SIDE_E : SIDE_W;
            default: return (k == 0) ? SIDE_N : (k == 1) ? SIDE_E : SIDE_W;
        endcase
    endfunction

endpackage

// File: rtl/fx_fifo.sv
// Packet FIFO holding whole packets.
// Assumes DEPTH is a power of two; a write while full and a read while
// empty are ignored (the surrounding logic never issues them).
module fx_fifo #(
    parameter int PKT_W = 64,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PKT_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [PKT_W-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] CNT_MAX = (AW + 1)'(DEPTH);

    logic [PKT_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             do_wr, do_rd;

    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign full    = (cnt == CNT_MAX);
    assign empty   = (cnt == '0);
    assign rd_data = mem[rp];

    // Storage array write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && !do_rd && !full) |=> !empty);
endmodule

// File: rtl/fx_route_calc.sv
// XY dimension-ordered route for one destination, relative to this router.
// Assumes the destination X is in the low COORD_W bits and Y above it.
module fx_route_calc #(
    parameter int COORD_W = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input  logic [2*COORD_W-1:0]      dest,
    output logic [fx_pkg::NDIR-1:0]   dir
);
    localparam logic [COORD_W-1:0] MX = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] MY = COORD_W'(MY_Y);

    logic [COORD_W-1:0] dx, dy;
    assign dx = dest[COORD_W-1:0];
    assign dy = dest[2*COORD_W-1:COORD_W];

    // X first, then Y, then local delivery.
    always_comb begin
        if (dx > MX)      dir = fx_pkg::DIR_E;
        else if (dx < MX) dir = fx_pkg::DIR_W;
        else if (dy > MY) dir = fx_pkg::DIR_N;
        else if (dy < MY) dir = fx_pkg::DIR_S;
        else              dir = fx_pkg::DIR_L;
    end
endmodule

// File: rtl/fx_borrow_ctl.sv
// Borrowing controller: while the own FIFO is full and upstream offers a
// packet, picks the first eligible peer in slot order, holds a request to it
// and reports completion when that peer grants.
// Assumes upstream holds up_req and its packet stable until granted.
module fx_borrow_ctl #(
    parameter int PEERS     = 3,
    parameter int PORT_SIDE = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    up_req,
    input  logic                    own_full,
    input  logic [fx_pkg::NDIR-1:0] pkt_dir,
    input  logic [PEERS-1:0]        peer_full,
    input  logic [PEERS-1:0]        bor_gnt,
    output logic [PEERS-1:0]        bor_req,
    output logic                    bor_done
);
    localparam fx_pkg::side_e SIDE = fx_pkg::side_e'(PORT_SIDE[1:0]);

    logic [PEERS-1:0] fits, elig, pick, req_q;
    logic             active;

    // Per-slot acceptance from the turn rules of the peer's side.
    for (genvar k = 0; k < PEERS; k++) begin : g_slot
        localparam logic [fx_pkg::NDIR-1:0] ACC =
            fx_pkg::side_allowed(fx_pkg::peer_side(SIDE, k));
        assign fits[k] = |(pkt_dir & ACC);
        assign elig[k] = fits[k] && !peer_full[k];

        assert_turn_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
            bor_req[k] |-> fits[k]);
    end

    // First eligible slot in probe order.
    always_comb begin
        pick = '0;
        for (int k = 0; k < PEERS; k++) begin
            if (pick == '0 && elig[k]) pick[k] = 1'b1;
        end
    end

    assign active   = up_req && own_full;
    assign bor_req  = active ? req_q : '0;
    assign bor_done = |(bor_req & bor_gnt);

    // Request register: probe, hold, complete or withdraw.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (bor_done) begin
            req_q <= '0;
        end else if (req_q != '0) begin
            if (!active || (|(req_q & peer_full))) req_q <= '0;
        end else if (active) begin
            req_q <= pick;
        end
    end

    assert_req_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bor_req));
    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bor_done |=> (bor_req == '0));
    assert_withdraw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(bor_req & peer_full)) && !bor_done |=> (bor_req == '0));
endmodule

// File: rtl/fx_lend_arb.sv
// Accepts at most one peer packet per cycle, lowest slot first, and only
// when the own write port is free and the FIFO has room.
module fx_lend_arb #(
    parameter int PEERS = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PEERS-1:0] lend_req,
    input  logic             blocked,
    output logic [PEERS-1:0] lend_gnt,
    output logic [SEL_W-1:0] sel,
    output logic             lend_we
);
    // Fixed-priority pick of one offering peer.
    always_comb begin
        lend_gnt = '0;
        sel      = '0;
        if (!blocked) begin
            for (int k = 0; k < PEERS; k++) begin
                if (lend_gnt == '0 && lend_req[k]) begin
                    lend_gnt[k] = 1'b1;
                    sel         = SEL_W'(k);
                end
            end
        end
    end

    assign lend_we = |lend_gnt;

    assert_lend_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lend_gnt));
    assert_lend_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lend_gnt & ~lend_req) == '0);
endmodule

// File: rtl/fx_inport.sv
// Mesh router input port with space borrowing.
// Stores whole packets, requests the XY output for the head packet, hands an
// upstream packet to a peer FIFO when its own is full, and accepts packets
// that peers hand to it. Own upstream writes take priority over peer writes.
// Assumes upstream keeps up_req and up_pkt stable until up_gnt.
module fx_inport #(
    parameter int PKT_W     = 64,
    parameter int DEPTH     = 4,
    parameter int COORD_W   = 3,
    parameter int MY_X      = 2,
    parameter int MY_Y      = 2,
    parameter int PORT_SIDE = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_req,
    input  logic [PKT_W-1:0]   up_pkt,
    output logic               up_gnt,
    output logic               up_full,
    output logic [4:0]         out_req,
    input  logic [4:0]         out_gnt,
    output logic [PKT_W-1:0]   head_pkt,
    output logic [2:0]         bor_req,
    input  logic [2:0]         bor_gnt,
    input  logic [2:0]         peer_full,
    output logic [PKT_W-1:0]   bor_pkt,
    input  logic [2:0]         lend_req,
    input  logic [3*PKT_W-1:0] lend_pkt,
    output logic [2:0]         lend_gnt
);
    localparam int PEERS = 3;
    localparam int SEL_W = $clog2(PEERS);

    logic                    full, empty, direct_wr, bor_done, lend_we, wr_en, rd_en;
    logic [SEL_W-1:0]        sel;
    logic [PKT_W-1:0]        wr_data;
    logic [fx_pkg::NDIR-1:0] up_dir, head_dir;

    // Own upstream write whenever there is room.
    assign direct_wr = up_req && !full;
    assign up_gnt    = direct_wr || bor_done;
    assign up_full   = full;
    assign bor_pkt   = up_pkt;

    // Write multiplexer: own upstream first, else the granted peer.
    always_comb begin
        if (direct_wr) wr_data = up_pkt;
        else           wr_data = lend_pkt[sel*PKT_W +: PKT_W];
    end
    assign wr_en = direct_wr || lend_we;

    assign out_req = empty ? '0 : head_dir;
    assign rd_en   = |(out_req & out_gnt);

    fx_fifo #(.PKT_W(PKT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(head_pkt), .empty(empty), .full(full)
    );

    fx_route_calc #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route_head (
        .dest(head_pkt[2*COORD_W-1:0]), .dir(head_dir)
    );

    fx_route_calc #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route_up (
        .dest(up_pkt[2*COORD_W-1:0]), .dir(up_dir)
    );

    fx_borrow_ctl #(.PEERS(PEERS), .PORT_SIDE(PORT_SIDE)) u_borrow (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .own_full(full),
        .pkt_dir(up_dir), .peer_full(peer_full), .bor_gnt(bor_gnt),
        .bor_req(bor_req), .bor_done(bor_done)
    );

    fx_lend_arb #(.PEERS(PEERS), .SEL_W(SEL_W)) u_lend (
        .clk(clk), .rst_n(rst_n), .lend_req(lend_req), .blocked(full || up_req),
        .lend_gnt(lend_gnt), .sel(sel), .lend_we(lend_we)
    );

    assert_gnt_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        up_gnt |-> up_req);
    assert_head_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> $onehot(out_req));
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && up_full && ((bor_req & bor_gnt) == '0)) |-> !up_gnt);
    assert_lend_yield_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|lend_gnt) |-> !(up_gnt && !up_full));
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (out_req == '0 && !up_full));
endmodule

// File: tb/fx_inport_tb.sv
module fx_inport_tb_top;
    localparam int PKT_W = 64;
    localparam int DEPTH = 4;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               up_req;
    logic [PKT_W-1:0]   up_pkt;
    logic               up_gnt, up_full;
    logic [4:0]         out_req, out_gnt;
    logic [PKT_W-1:0]   head_pkt, bor_pkt;
    logic [2:0]         bor_req, bor_gnt, peer_full, lend_req, lend_gnt;
    logic [3*PKT_W-1:0] lend_pkt;

    int nchk = 0;
    int nerr = 0;
    logic [PKT_W-1:0] model [$];

    always #4 clk = ~clk;

    fx_inport #(.PKT_W(PKT_W), .DEPTH(DEPTH), .COORD_W(3), .MY_X(2), .MY_Y(2),
                .PORT_SIDE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_pkt(up_pkt),
        .up_gnt(up_gnt), .up_full(up_full), .out_req(out_req), .out_gnt(out_gnt),
        .head_pkt(head_pkt), .bor_req(bor_req), .bor_gnt(bor_gnt),
        .peer_full(peer_full), .bor_pkt(bor_pkt), .lend_req(lend_req),
        .lend_pkt(lend_pkt), .lend_gnt(lend_gnt)
    );

    // Expected XY direction for router (2,2): L=1 E=2 W=4 N=8 S=16.
    function automatic logic [4:0] exp_route(logic [PKT_W-1:0] p);
        if (p[2:0] > 3'd2)      return 5'b00010;
        else if (p[2:0] < 3'd2) return 5'b00100;
        else if (p[5:3] > 3'd2) return 5'b01000;
        else if (p[5:3] < 3'd2) return 5'b10000;
        else                    return 5'b00001;
    endfunction

    // Expected probe choice for an East port: slots West, North, South.
    function automatic logic [2:0] exp_slot(logic [4:0] d, logic [2:0] pf);
        logic [4:0] acc [3];
        acc[0] = 5'b11111 & ~5'b00100;  // West buffer: L,E,N,S
        acc[1] = 5'b10001;              // North buffer: L,S
        acc[2] = 5'b01001;              // South buffer: L,N
        acc[0] = 5'b11011;              // L,E,N,S encoded
        for (int k = 0; k < 3; k++) begin
            if (!pf[k] && ((d & acc[k]) != 0)) return 3'(1 << k);
        end
        return 3'b000;
    endfunction

    function automatic logic [PKT_W-1:0] mk_pkt(logic [2:0] x, logic [2:0] y);
        logic [PKT_W-1:0] p;
        p = {$urandom, $urandom};
        p[5:0] = {y, x};
        return p;
    endfunction

    task automatic chk(input string tag, input logic [PKT_W-1:0] act,
                       input logic [PKT_W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Upstream write into a FIFO with room (R2).
    task automatic push_direct(input logic [PKT_W-1:0] p);
        up_req = 1'b1; up_pkt = p;
        #1 chk("R2 direct grant", {63'd0, up_gnt}, 64'd1);
        model.push_back(p);
        tick();
        up_req = 1'b0;
    endtask

    // Pop the head with a wrong grant first, then the right one (R4, R5).
    task automatic pop_check();
        logic [4:0] e;
        e = exp_route(model[0]);
        #1 chk("R4 out_req", {59'd0, out_req}, {59'd0, e});
        chk("R2 head order", head_pkt, model[0]);
        out_gnt = ~e;
        tick();
        #1 chk("R5 wrong grant ignored", head_pkt, model[0]);
        out_gnt = e;
        tick();
        out_gnt = '0;
        void'(model.pop_front());
        #1 if (model.size() == 0) chk("R5 popped", {59'd0, out_req}, 64'd0);
        else chk("R5 popped next head", head_pkt, model[0]);
    endtask

    // One borrow attempt with the FIFO full. mode 0: grant, 1: peer fills.
    task automatic borrow_try(input logic [PKT_W-1:0] p, input logic [2:0] pf,
                              input int mode);
        logic [2:0] e;
        e = exp_slot(exp_route(p), pf);
        up_req = 1'b1; up_pkt = p; peer_full = pf;
        #1 chk("R9 no grant while probing", {63'd0, up_gnt}, 64'd0);
        chk("R3 full flag", {63'd0, up_full}, 64'd1);
        tick();
        #1 chk("R6 R7 probe choice", {61'd0, bor_req}, {61'd0, e});
        if (e == 3'b000) begin
            chk("R9 stalled", {63'd0, up_gnt}, 64'd0);
        end else if (mode == 0) begin
            bor_gnt = e;
            #1 chk("R8 grant on borrow", {63'd0, up_gnt}, 64'd1);
            chk("R8 packet handed", bor_pkt, p);
            tick();
            bor_gnt = '0;
            #1 chk("R8 request cleared", {61'd0, bor_req}, 64'd0);
        end else begin
            peer_full = pf | e;
            tick();
            #1 chk("R11 request withdrawn", {61'd0, bor_req}, 64'd0);
            chk("R11 no grant", {63'd0, up_gnt}, 64'd0);
        end
        up_req = 1'b0; peer_full = '0;
        tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        model.delete();
        tick();
    endtask

    initial begin
        #(8 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        up_req = 0; up_pkt = '0; out_gnt = '0; bor_gnt = '0; peer_full = '0;
        lend_req = '0; lend_pkt = '0; rst_n = 0;
        void'($urandom(32'h5eed_1234));
        tick();
        do_reset();
        #1 chk("R1 out_req after reset", {59'd0, out_req}, 64'd0);
        chk("R1 bor_req after reset", {61'd0, bor_req}, 64'd0);
        chk("R1 up_full after reset", {63'd0, up_full}, 64'd0);
        chk("R1 lend_gnt idle", {61'd0, lend_gnt}, 64'd0);

        // Directed routes: each direction once.
        push_direct(mk_pkt(3'd5, 3'd2)); pop_check();   // East
        push_direct(mk_pkt(3'd0, 3'd7)); pop_check();   // West (X first)
        push_direct(mk_pkt(3'd2, 3'd6)); pop_check();   // North
        push_direct(mk_pkt(3'd2, 3'd1)); pop_check();   // South
        push_direct(mk_pkt(3'd2, 3'd2)); pop_check();   // Local

        // Random fill and drain.
        for (int i = 0; i < 60; i++) begin
            if (model.size() < DEPTH && (model.size() == 0 || $urandom_range(0, 1) == 1))
                push_direct(mk_pkt(3'($urandom), 3'($urandom)));
            else
                pop_check();
        end
        while (model.size() > 0) pop_check();

        // Fill to full, check full and ordering (R3).
        for (int i = 0; i < DEPTH; i++) push_direct(mk_pkt(3'($urandom), 3'($urandom)));
        #1 chk("R3 full at depth", {63'd0, up_full}, 64'd1);
        lend_req = 3'b001; lend_pkt = {3{64'hDEAD}};
        #1 chk("R10 no lend when full", {61'd0, lend_gnt}, 64'd0);
        lend_req = '0;

        // Directed borrows.
        borrow_try(mk_pkt(3'd2, 3'd6), 3'b000, 0);  // North -> West slot
        borrow_try(mk_pkt(3'd2, 3'd1), 3'b001, 0);  // South -> North slot
        borrow_try(mk_pkt(3'd2, 3'd6), 3'b001, 0);  // North -> South slot
        borrow_try(mk_pkt(3'd0, 3'd2), 3'b000, 0);  // West: no buffer may hold it
        borrow_try(mk_pkt(3'd6, 3'd2), 3'b001, 0);  // East with West full: none
        borrow_try(mk_pkt(3'd2, 3'd2), 3'b000, 1);  // Local, peer fills first
        for (int i = 0; i < 40; i++)
            borrow_try(mk_pkt(3'($urandom), 3'($urandom)), 3'($urandom),
                       int'($urandom_range(0, 1)));
        // FIFO contents untouched by borrowing.
        while (model.size() > 0) pop_check();

        // Peer offers (R10).
        lend_pkt = {mk_pkt(3'd2, 3'd5), mk_pkt(3'd2, 3'd0), mk_pkt(3'd7, 3'd7)};
        lend_req = 3'b110;
        #1 chk("R10 lowest slot wins", {61'd0, lend_gnt}, 64'd2);
        model.push_back(lend_pkt[PKT_W +: PKT_W]);
        tick();
        lend_req = 3'b111;
        up_req = 1'b1; up_pkt = mk_pkt(3'd1, 3'd1);
        #1 chk("R10 upstream has priority", {61'd0, lend_gnt}, 64'd0);
        chk("R2 upstream granted", {63'd0, up_gnt}, 64'd1);
        model.push_back(up_pkt);
        tick();
        up_req = 1'b0; lend_req = '0;
        while (model.size() > 0) pop_check();

        // Reset in the middle of traffic (R1).
        push_direct(mk_pkt(3'd4, 3'd4));
        push_direct(mk_pkt(3'd1, 3'd4));
        do_reset();
        #1 chk("R1 FIFO emptied by reset", {59'd0, out_req}, 64'd0);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule